// File: doc/BRIEF.md
# Conflict-Only Instruction Cache

This block sits beside a single-ported program memory that serves two kinds of access: instruction fetches and data accesses. When a fetch and a data access both want the memory in the same cycle, a plain design would have to stall every time. This block keeps a small store of instructions so that the two accesses can proceed together. The core reports each such collision on `conflict_i`. On a hit, the block supplies the instruction from its own lines, and the data access keeps the memory port.

Only colliding fetches ever fill a line. A fetch with no collision goes straight to memory and leaves the lines unchanged. When a colliding fetch misses, the data access takes the memory first and the block raises `stall_o` for one cycle. On the next cycle it fetches the deferred instruction from memory, hands it to the core, and writes it into the cache.

The store is direct-mapped. It has 32 lines selected by the low five address bits, and each line holds a valid bit, a tag and a 48-bit instruction. A flush clears every line in one cycle.

Top module: `icc_conflict_cache`

## Requirements
- R1: After reset every line is empty, so the first colliding fetch to any address misses.
- R2: A fetch without collision (`fetch_req_i`=1, `conflict_i`=0) drives `mem_req_o`=1 with `mem_addr_o` equal to the fetch address. In the same cycle it returns `instr_o` equal to `mem_rdata_i` with `instr_valid_o`=1 and `stall_o`=0.
- R3: A fetch without collision never fills a line, so a later colliding fetch to the same address misses.
- R4: A colliding fetch that misses raises `stall_o` for exactly one cycle. In that cycle `instr_valid_o`=0 and `mem_req_o`=0.
- R5: In the cycle after a miss, the block drives `mem_req_o`=1 with `mem_addr_o` equal to the stalled address, returns that word with `instr_valid_o`=1 and holds `stall_o`=0. Fetch inputs presented in this cycle are ignored.
- R6: The word fetched in the deferred cycle is stored. A later colliding fetch to the same address hits and returns the stored word with `instr_valid_o`=1 in the same cycle, with `mem_req_o`=0 and `stall_o`=0.
- R7: Lines are indexed by address bits [4:0] and tagged with the remaining upper bits. A colliding fetch with the same index but a different tag misses, and its fill evicts the old line. Lines at other indices are unaffected.
- R8: A cycle with `flush_i`=1 empties all lines, so every following colliding fetch misses until it is refilled.
- R9: Flush takes priority over a fill in the same cycle. The deferred word is still returned to the core, but it is not kept.
- R10: With `fetch_req_i`=0 the block is idle (`instr_valid_o`=0, `mem_req_o`=0, `stall_o`=0) whatever the value of `conflict_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines |
| fetch_req_i | input | 1 | Instruction fetch request |
| conflict_i | input | 1 | A data access uses program memory in this cycle |
| fetch_addr_i | input | 24 | Instruction fetch address |
| mem_req_o | output | 1 | Instruction read on the memory port |
| mem_addr_o | output | 24 | Memory read address |
| mem_rdata_i | input | 48 | Memory read data, valid in the same cycle |
| instr_o | output | 48 | Instruction to the core |
| instr_valid_o | output | 1 | `instr_o` holds a valid instruction |
| stall_o | output | 1 | Miss on a colliding fetch; the core holds for one cycle |

## Verification
The bench aims at the cases where the fill rule is easy to get wrong. A fetch with no collision must not fill a line, or R3 would see a hit. Two addresses that share an index but differ in tag must not alias, or a stale word would come back as a hit. The deferred cycle must use the latched address and not the live inputs; a design that made that mistake would return the wrong word while the core presents a new address. A flush that lands in the same cycle as a fill must win, or the line would survive. A flush is also checked on its own, and the bench repeats the reset check midway through the run, since a design that missed either case would keep serving old lines.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int unsigned ADDR_W_DEF  = 24;
  localparam int unsigned INSTR_W_DEF = 48;
  localparam int unsigned LINES_DEF   = 32;

  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_DEFER  = 1'b1
  } icc_state_e;
endpackage

// File: rtl/icc_tag_store.sv
module icc_tag_store #(
  parameter int unsigned ADDR_W = icc_pkg::ADDR_W_DEF,
  parameter int unsigned LINES  = icc_pkg::LINES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              hit_o,
  input  logic              fill_we_i,
  input  logic [ADDR_W-1:0] fill_addr_i
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;

  assign lk_idx   = lk_addr_i[IDX_W-1:0];
  assign lk_tag   = lk_addr_i[ADDR_W-1:IDX_W];
  assign fill_idx = fill_addr_i[IDX_W-1:0];
  assign fill_tag = fill_addr_i[ADDR_W-1:IDX_W];

  // flush wins over a fill in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_we_i) begin
      valid_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < LINES; i++) begin
      if (fill_we_i && !flush_i && fill_idx == IDX_W'(i)) tag_q[i] <= fill_tag;
    end
  end

  assign hit_o = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0)); // R8
  AST_FLUSH_BEATS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && fill_we_i) |=> !valid_q[$past(fill_idx)]); // R9
  AST_FILL_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_we_i && !flush_i) |=> valid_q[$past(fill_idx)]); // R6
endmodule

// File: rtl/icc_data_store.sv
module icc_data_store #(
  parameter int unsigned INSTR_W = icc_pkg::INSTR_W_DEF,
  parameter int unsigned LINES   = icc_pkg::LINES_DEF,
  localparam int unsigned IDX_W  = $clog2(LINES)
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [INSTR_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [INSTR_W-1:0] rdata_o
);
  logic [INSTR_W-1:0] line_q [LINES];

  always_ff @(posedge clk_i) begin
    if (we_i) line_q[wr_idx_i] <= wdata_i;
  end

  assign rdata_o = line_q[rd_idx_i];
endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl #(
  parameter int unsigned ADDR_W = icc_pkg::ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic              conflict_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              hit_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              instr_valid_o,
  output logic              stall_o,
  output logic              sel_cache_o,
  output logic              fill_we_o,
  output logic [ADDR_W-1:0] fill_addr_o
);
  import icc_pkg::*;

  icc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    state_d       = state_q;
    mem_req_o     = 1'b0;
    mem_addr_o    = fetch_addr_i;
    instr_valid_o = 1'b0;
    stall_o       = 1'b0;
    sel_cache_o   = 1'b0;
    fill_we_o     = 1'b0;
    fill_addr_o   = addr_q;
    unique case (state_q)
      ST_LOOKUP: begin
        if (fetch_req_i) begin
          if (!conflict_i) begin
            mem_req_o     = 1'b1;
            instr_valid_o = 1'b1;
          end else if (hit_i) begin
            instr_valid_o = 1'b1;
            sel_cache_o   = 1'b1;
          end else begin
            stall_o = 1'b1;
            state_d = ST_DEFER;
          end
        end
      end
      ST_DEFER: begin
        // data access had the port last cycle; fetch the held address now
        mem_req_o     = 1'b1;
        mem_addr_o    = addr_q;
        instr_valid_o = 1'b1;
        fill_we_o     = 1'b1;
        state_d       = ST_LOOKUP;
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOOKUP;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (stall_o) addr_q <= fetch_addr_i;
    end
  end

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o); // R4
  AST_STALL_NO_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!instr_valid_o && !mem_req_o)); // R4
  AST_DEFER_DELIVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (instr_valid_o && mem_req_o)); // R5
  AST_DEFER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (mem_addr_o == $past(fetch_addr_i))); // R5
  AST_FILL_ONLY_AFTER_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_o |-> $past(stall_o)); // R3
endmodule

// File: rtl/icc_conflict_cache.sv
module icc_conflict_cache #(
  parameter int unsigned ADDR_W  = icc_pkg::ADDR_W_DEF,
  parameter int unsigned INSTR_W = icc_pkg::INSTR_W_DEF,
  parameter int unsigned LINES   = icc_pkg::LINES_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               fetch_req_i,
  input  logic               conflict_i,
  input  logic [ADDR_W-1:0]  fetch_addr_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic [INSTR_W-1:0] mem_rdata_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic               instr_valid_o,
  output logic               stall_o
);
  localparam int unsigned IDX_W = $clog2(LINES);

  logic               hit, sel_cache, fill_we;
  logic [ADDR_W-1:0]  fill_addr;
  logic [INSTR_W-1:0] cache_rdata;

  icc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_req_i   (fetch_req_i),
    .conflict_i    (conflict_i),
    .fetch_addr_i  (fetch_addr_i),
    .hit_i         (hit),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .instr_valid_o (instr_valid_o),
    .stall_o       (stall_o),
    .sel_cache_o   (sel_cache),
    .fill_we_o     (fill_we),
    .fill_addr_o   (fill_addr)
  );

  icc_tag_store #(.ADDR_W(ADDR_W), .LINES(LINES)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .lk_addr_i   (fetch_addr_i),
    .hit_o       (hit),
    .fill_we_i   (fill_we),
    .fill_addr_i (fill_addr)
  );

  icc_data_store #(.INSTR_W(INSTR_W), .LINES(LINES)) u_data (
    .clk_i    (clk_i),
    .we_i     (fill_we),
    .wr_idx_i (fill_addr[IDX_W-1:0]),
    .wdata_i  (mem_rdata_i),
    .rd_idx_i (fetch_addr_i[IDX_W-1:0]),
    .rdata_o  (cache_rdata)
  );

  always_comb begin
    if (!instr_valid_o) instr_o = '0;
    else if (sel_cache) instr_o = cache_rdata;
    else                instr_o = mem_rdata_i;
  end

  AST_HIT_SERVES_CACHE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && !mem_req_o) |-> (instr_o == cache_rdata)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_req_i && !$past(stall_o)) |-> (!instr_valid_o && !mem_req_o && !stall_o)); // R10
endmodule

// File: tb/icc_conflict_cache_test.sv
module icc_conflict_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic        conflict_i = 1'b0;
  logic [23:0] fetch_addr_i = '0;
  logic        mem_req_o;
  logic [23:0] mem_addr_o;
  logic [47:0] mem_rdata_i;
  logic [47:0] instr_o;
  logic        instr_valid_o;
  logic        stall_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [47:0] word_of(logic [23:0] a);
    return {a ^ 24'h5A5A5A, ~a};
  endfunction

  // bench-side program memory, combinational read
  assign mem_rdata_i = word_of(mem_addr_o);

  icc_conflict_cache uut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .fetch_req_i(fetch_req_i), .conflict_i(conflict_i), .fetch_addr_i(fetch_addr_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .instr_o(instr_o), .instr_valid_o(instr_valid_o), .stall_o(stall_o)
  );

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step(logic req, logic conf, logic fl, logic [23:0] addr,
                      logic ev, logic es, logic em, logic [23:0] ia, string rq);
    @(negedge clk);
    fetch_req_i = req; conflict_i = conf; flush_i = fl; fetch_addr_i = addr;
    #1;
    chk(instr_valid_o == ev, rq, "instr_valid_o", 64'(instr_valid_o), 64'(ev));
    chk(stall_o == es, rq, "stall_o", 64'(stall_o), 64'(es));
    chk(mem_req_o == em, rq, "mem_req_o", 64'(mem_req_o), 64'(em));
    if (em) chk(mem_addr_o == ia, rq, "mem_addr_o", 64'(mem_addr_o), 64'(ia));
    if (ev) chk(instr_o == word_of(ia), rq, "instr_o", 64'(instr_o), 64'(word_of(ia)));
  endtask

  typedef struct packed {
    logic        req;
    logic        conf;
    logic [23:0] addr;
    logic        ev;
    logic        es;
    logic        em;
    logic [23:0] ia;
  } vec_t;

  // A=0x10 and B=0x410 share index 0x10; C=0x31 sits at index 0x11
  localparam vec_t VECS [16] = '{
    '{1'b0, 1'b0, 24'h000010, 1'b0, 1'b0, 1'b0, 24'h000000}, // R10 idle
    '{1'b0, 1'b1, 24'h000010, 1'b0, 1'b0, 1'b0, 24'h000000}, // R10 conflict alone
    '{1'b1, 1'b0, 24'h000010, 1'b1, 1'b0, 1'b1, 24'h000010}, // R2 plain fetch A
    '{1'b1, 1'b1, 24'h000010, 1'b0, 1'b1, 1'b0, 24'h000000}, // R1 R3 R4 miss A
    '{1'b1, 1'b1, 24'h000031, 1'b1, 1'b0, 1'b1, 24'h000010}, // R5 deferred A, C ignored
    '{1'b1, 1'b1, 24'h000010, 1'b1, 1'b0, 1'b0, 24'h000010}, // R6 hit A
    '{1'b1, 1'b1, 24'h000410, 1'b0, 1'b1, 1'b0, 24'h000000}, // R7 tag mismatch B
    '{1'b0, 1'b0, 24'h000000, 1'b1, 1'b0, 1'b1, 24'h000410}, // R5 deferred B
    '{1'b1, 1'b1, 24'h000410, 1'b1, 1'b0, 1'b0, 24'h000410}, // R6 hit B
    '{1'b1, 1'b1, 24'h000010, 1'b0, 1'b1, 1'b0, 24'h000000}, // R7 A evicted
    '{1'b0, 1'b0, 24'h000000, 1'b1, 1'b0, 1'b1, 24'h000010}, // R5 deferred A
    '{1'b1, 1'b1, 24'h000031, 1'b0, 1'b1, 1'b0, 24'h000000}, // R4 miss C
    '{1'b0, 1'b1, 24'h000010, 1'b1, 1'b0, 1'b1, 24'h000031}, // R5 deferred C
    '{1'b1, 1'b1, 24'h000031, 1'b1, 1'b0, 1'b0, 24'h000031}, // R6 hit C
    '{1'b1, 1'b1, 24'h000010, 1'b1, 1'b0, 1'b0, 24'h000010}, // R7 A kept at other index
    '{1'b1, 1'b0, 24'h000031, 1'b1, 1'b0, 1'b1, 24'h000031}  // R2 plain fetch C
  };

  initial begin
    #1;
    chk(!instr_valid_o && !stall_o && !mem_req_o, "R1", "outputs in reset",
        64'({instr_valid_o, stall_o, mem_req_o}), 64'(0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    foreach (VECS[i]) begin
      step(VECS[i].req, VECS[i].conf, 1'b0, VECS[i].addr,
           VECS[i].ev, VECS[i].es, VECS[i].em, VECS[i].ia, $sformatf("vec%0d", i));
    end

    // R8: flush empties every line
    step(1'b0, 1'b0, 1'b1, 24'h0, 1'b0, 1'b0, 1'b0, 24'h0, "R8");
    step(1'b1, 1'b1, 1'b0, 24'h000010, 1'b0, 1'b1, 1'b0, 24'h0, "R8");
    step(1'b0, 1'b0, 1'b0, 24'h0, 1'b1, 1'b0, 1'b1, 24'h000010, "R8");
    step(1'b1, 1'b1, 1'b0, 24'h000031, 1'b0, 1'b1, 1'b0, 24'h0, "R8");
    step(1'b0, 1'b0, 1'b0, 24'h0, 1'b1, 1'b0, 1'b1, 24'h000031, "R8");

    // R9: flush during the deferred cycle drops the fill
    step(1'b1, 1'b1, 1'b0, 24'h000052, 1'b0, 1'b1, 1'b0, 24'h0, "R9");
    step(1'b0, 1'b0, 1'b1, 24'h0, 1'b1, 1'b0, 1'b1, 24'h000052, "R9");
    step(1'b1, 1'b1, 1'b0, 24'h000052, 1'b0, 1'b1, 1'b0, 24'h0, "R9");
    step(1'b0, 1'b0, 1'b0, 24'h0, 1'b1, 1'b0, 1'b1, 24'h000052, "R9");
    step(1'b1, 1'b1, 1'b0, 24'h000010, 1'b0, 1'b1, 1'b0, 24'h0, "R9");
    step(1'b0, 1'b0, 1'b0, 24'h0, 1'b1, 1'b0, 1'b1, 24'h000010, "R9");
    step(1'b1, 1'b1, 1'b0, 24'h000052, 1'b1, 1'b0, 1'b0, 24'h000052, "R6");

    // R1: reset mid-run leaves the cache empty
    @(negedge clk);
    fetch_req_i = 1'b0; conflict_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(!instr_valid_o && !stall_o && !mem_req_o, "R1", "outputs in reset",
        64'({instr_valid_o, stall_o, mem_req_o}), 64'(0));
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b1, 1'b1, 1'b0, 24'h000052, 1'b0, 1'b1, 1'b0, 24'h0, "R1");
    step(1'b0, 1'b0, 1'b0, 24'h0, 1'b1, 1'b0, 1'b1, 24'h000052, "R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule